// File: doc/BRIEF.md
# Single-Cycle Five-Instruction 32-bit Core

This block is a small 32-bit processor that completes one instruction per clock. It supports five instructions: register add, register subtract, add with a signed 16-bit constant, word load and word store. Each cycle the core takes an instruction from a word-indexed program store and decodes it as either the three-register form or the constant form. It reads two operands from a 32-entry register file and then either writes a result back or moves a word to or from an internal byte-addressed data store.

A word in the data store occupies four consecutive bytes. The byte with the lowest address holds the most significant eight bits. The program store is filled through a write port while reset is held. A debug port reads any register, and a second debug port reads any data byte, both combinationally. Execution stops for good on an unsupported encoding or on a word access that is not 4-byte aligned. Both conditions are reported on output flags.

Top module: `rcore_top`

## Requirements
- R1: While `rst` is high (synchronous, active high), all registers, all data bytes, `halted` and `misalign` are cleared, the fetch address returns to 0 and nothing executes. After release, one instruction completes per clock and the fetch address grows by 4.
- R2: Instruction layout is op[31:26], rs[25:21], rt[20:16], rd[15:11], bits[10:6] unused, fn[5:0]. With op 0 and fn 32, register rd receives rs + rt modulo 2^32, with no trap on carry.
- R3: With op 0 and fn 34, register rd receives rs - rt modulo 2^32.
- R4: Op 8 writes rs plus the sign-extended constant in bits[15:0] into register rt.
- R5: Op 35 loads the word at byte address rs + sign-extended bits[15:0] into register rt. Negative offsets work.
- R6: Op 43 stores register rt at the same kind of address. Byte address A receives bits 31:24, A+1 bits 23:16, A+2 bits 15:8 and A+3 bits 7:0.
- R7: Register 0 always reads 0. An instruction that names it as destination changes nothing visible.
- R8: Any op other than 0, 8, 35 or 43, or op 0 with fn other than 32 or 34, sets `halted`. That instruction has no effect, and no later instruction runs until reset.
- R9: A load or store whose address has bits[1:0] nonzero sets `misalign` and `halted`. It writes neither memory nor registers.
- R10: `dbg_rdata` shows register `dbg_reg` and `dbg_mbyte` shows data byte `dbg_maddr`, both without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Program store write enable |
| ld_addr | input | 5 | Program word index |
| ld_data | input | 32 | Program word to write |
| dbg_reg | input | 5 | Register number for debug read |
| dbg_rdata | output | 32 | Value of the selected register |
| dbg_maddr | input | 6 | Data byte address for debug read |
| dbg_mbyte | output | 8 | Value of the selected data byte |
| halted | output | 1 | Core has stopped |
| misalign | output | 1 | Stop was caused by an unaligned access |

## Verification
Wrong decode or ALU state appears on `dbg_rdata` one clock after the faulty instruction. The program runs on from that value, so a single bad result also corrupts every dependent register and store. Byte-lane errors in the data store appear on `dbg_mbyte` at the four addresses of the stored word one clock after the store. A stop that comes too late shows up at the ports as a register or byte that changed after the offending instruction. A stop that comes too early shows up as a missing result; the bench reads both after the run has settled.

// File: rtl/rcore_pkg.sv
package rcore_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;
  localparam logic [5:0] FN_ADD   = 6'd32;
  localparam logic [5:0] FN_SUB   = 6'd34;

  typedef enum logic [2:0] {
    K_BAD   = 3'd0,
    K_ADD   = 3'd1,
    K_SUB   = 3'd2,
    K_ADDI  = 3'd3,
    K_LOAD  = 3'd4,
    K_STORE = 3'd5
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic             wr_en;
    logic [RIDX-1:0]  wr_idx;
    logic [RIDX-1:0]  rs;
    logic [RIDX-1:0]  rt;
    logic [XLEN-1:0]  imm;
    logic             mem_rd;
    logic             mem_wr;
  } ctl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] wrap_add(input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    return a + b;
  endfunction

  function automatic logic [XLEN-1:0] wrap_sub(input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    return a - b;
  endfunction
endpackage

// File: rtl/rcore_imem.sv
module rcore_imem #(
  parameter int DEPTH = 32,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [W-1:0]  ld_data,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (ld_en) words[ld_addr] <= ld_data;
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/rcore_decode.sv
module rcore_decode
  import rcore_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ctl_t            ctl
);
  logic [5:0] op;
  logic [5:0] fn;
  logic       unused_shamt;

  assign op           = instr[31:26];
  assign fn           = instr[5:0];
  assign unused_shamt = ^instr[10:6];

  always_comb begin
    ctl        = '0;
    ctl.kind   = K_BAD;
    ctl.rs     = instr[25:21];
    ctl.rt     = instr[20:16];
    ctl.imm    = sext16(instr[15:0]);
    case (op)
      OP_RTYPE: begin
        if (fn == FN_ADD) begin
          ctl.kind   = K_ADD;
          ctl.wr_en  = 1'b1;
          ctl.wr_idx = instr[15:11];
        end else if (fn == FN_SUB) begin
          ctl.kind   = K_SUB;
          ctl.wr_en  = 1'b1;
          ctl.wr_idx = instr[15:11];
        end
      end
      OP_ADDI: begin
        ctl.kind   = K_ADDI;
        ctl.wr_en  = 1'b1;
        ctl.wr_idx = instr[20:16];
      end
      OP_LOAD: begin
        ctl.kind   = K_LOAD;
        ctl.wr_en  = 1'b1;
        ctl.wr_idx = instr[20:16];
        ctl.mem_rd = 1'b1;
      end
      OP_STORE: begin
        ctl.kind   = K_STORE;
        ctl.mem_wr = 1'b1;
      end
      default: ctl.kind = K_BAD;
    endcase
  end

  // R8: an unsupported encoding never requests a write of any kind
  always_comb begin
    p_bad_is_inert_r8: assert (!(ctl.kind == K_BAD && (ctl.wr_en || ctl.mem_rd || ctl.mem_wr)));
  end

  // R6: a store never also writes a register
  always_comb begin
    p_store_no_wb_r6: assert (!(ctl.mem_wr && (ctl.wr_en || ctl.mem_rd)));
  end
endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd2,
  input  logic [AW-1:0] ra3,
  output logic [W-1:0]  rd3
);
  logic [W-1:0] regs [NREG];

  function automatic logic [W-1:0] rd_port(input logic [AW-1:0] a,
                                           input logic [W-1:0]  v);
    return (a == '0) ? '0 : v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd1 = rd_port(ra1, regs[ra1]);
  assign rd2 = rd_port(ra2, regs[ra2]);
  assign rd3 = rd_port(ra3, regs[ra3]);

  // R7: the storage of register 0 stays zero whatever is written
  p_r0_stays_zero_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (regs[0] == '0));

  // R2: an accepted write is visible in the next cycle
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    (we && waddr != '0) |=> (regs[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/rcore_dmem.sv
module rcore_dmem #(
  parameter int NBYTES = 64,
  parameter int W      = 32,
  localparam int AW    = $clog2(NBYTES),
  localparam int NB    = W / 8,
  localparam int LB    = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic [AW-1:0] dbg_addr,
  output logic [7:0]    dbg_byte
);
  logic [7:0] mem [NBYTES];

  function automatic logic [AW-1:0] lane_addr(input logic [AW-1:0] base, input int b);
    return AW'(base + AW'(b));
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBYTES; i++) mem[i] <= '0;
    end else if (we) begin
      for (int b = 0; b < NB; b++) mem[lane_addr(addr, b)] <= wdata[W-1-8*b -: 8];
    end
  end

  always_comb begin
    for (int b = 0; b < NB; b++) rdata[W-1-8*b -: 8] = mem[lane_addr(addr, b)];
  end

  assign dbg_byte = mem[dbg_addr];

  // R9: memory is only written at word-aligned addresses
  p_aligned_write_r9: assert property (@(posedge clk) disable iff (rst)
    we |-> (addr[LB-1:0] == '0));

  // R6: the lowest address of a stored word holds its top byte
  p_msb_first_r6: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem[$past(addr)] == $past(wdata[W-1 -: 8])));
endmodule

// File: rtl/rcore_top.sv
module rcore_top
  import rcore_pkg::*;
#(
  parameter int IM_DEPTH = 32,
  parameter int DM_BYTES = 64,
  parameter int NREG     = 32,
  localparam int IM_AW   = $clog2(IM_DEPTH),
  localparam int DM_AW   = $clog2(DM_BYTES),
  localparam int RAW     = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [IM_AW-1:0] ld_addr,
  input  logic [31:0]      ld_data,
  input  logic [RAW-1:0]   dbg_reg,
  output logic [31:0]      dbg_rdata,
  input  logic [DM_AW-1:0] dbg_maddr,
  output logic [7:0]       dbg_mbyte,
  output logic             halted,
  output logic             misalign
);
  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] instr;
  ctl_t            ctl;
  logic [XLEN-1:0] rs_val, rt_val;
  logic [XLEN-1:0] eff_addr;
  logic [XLEN-1:0] alu_res;
  logic [XLEN-1:0] dm_rdata;
  logic [XLEN-1:0] wb_data;
  logic            mem_req;
  logic            misal_now;
  logic            bad_now;
  logic            stop_now;
  logic            step;
  logic            rf_we;
  logic            dm_we;
  logic            unused_top;

  rcore_imem #(.DEPTH(IM_DEPTH), .W(XLEN)) u_imem (
    .clk     (clk),
    .ld_en   (ld_en),
    .ld_addr (ld_addr),
    .ld_data (ld_data),
    .raddr   (pc[IM_AW+1:2]),
    .rdata   (instr)
  );

  rcore_decode u_decode (
    .instr (instr),
    .ctl   (ctl)
  );

  rcore_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .waddr (ctl.wr_idx[RAW-1:0]),
    .wdata (wb_data),
    .ra1   (ctl.rs[RAW-1:0]),
    .rd1   (rs_val),
    .ra2   (ctl.rt[RAW-1:0]),
    .rd2   (rt_val),
    .ra3   (dbg_reg),
    .rd3   (dbg_rdata)
  );

  rcore_dmem #(.NBYTES(DM_BYTES), .W(XLEN)) u_dmem (
    .clk      (clk),
    .rst      (rst),
    .we       (dm_we),
    .addr     (eff_addr[DM_AW-1:0]),
    .wdata    (rt_val),
    .rdata    (dm_rdata),
    .dbg_addr (dbg_maddr),
    .dbg_byte (dbg_mbyte)
  );

  assign eff_addr = wrap_add(rs_val, ctl.imm);

  always_comb begin
    case (ctl.kind)
      K_ADD:   alu_res = wrap_add(rs_val, rt_val);
      K_SUB:   alu_res = wrap_sub(rs_val, rt_val);
      K_ADDI:  alu_res = eff_addr;
      default: alu_res = '0;
    endcase
  end

  assign mem_req   = ctl.mem_rd || ctl.mem_wr;
  assign misal_now = mem_req && (eff_addr[1:0] != 2'b00);
  assign bad_now   = (ctl.kind == K_BAD);
  assign stop_now  = bad_now || misal_now;
  assign step      = !rst && !halted && !stop_now;
  assign wb_data   = ctl.mem_rd ? dm_rdata : alu_res;
  assign rf_we     = step && ctl.wr_en;
  assign dm_we     = step && ctl.mem_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      halted   <= 1'b0;
      misalign <= 1'b0;
    end else if (!halted) begin
      if (stop_now) begin
        halted   <= 1'b1;
        misalign <= misal_now;
      end else begin
        pc <= pc + XLEN'(4);
      end
    end
  end

  assign unused_top = ^{pc[XLEN-1:IM_AW+2], pc[1:0], eff_addr[XLEN-1:DM_AW],
                        ctl.rs, ctl.rt, ctl.wr_idx};

  // R1: a running core moves to the next word each cycle
  p_pc_step_r1: assert property (@(posedge clk) disable iff (rst)
    (!halted && !stop_now) |=> (pc == $past(pc) + XLEN'(4)));

  // R8: once stopped, the core stays stopped
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R8: the fetch address is frozen while stopped
  p_pc_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(pc));

  // R8: a stopped core writes nothing
  p_quiet_when_halted_r8: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!rf_we && !dm_we));

  // R9: an unaligned access raises the flag in the next cycle
  p_misal_sets_r9: assert property (@(posedge clk) disable iff (rst)
    (!halted && misal_now) |=> (misalign && halted));

  // R9: the flag never appears without a stop
  p_misal_implies_halt_r9: assert property (@(posedge clk) disable iff (rst)
    misalign |-> halted);
endmodule

// File: tb/test_rcore_top.sv
module test_rcore_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [4:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [4:0]  dbg_reg = '0;
  logic [31:0] dbg_rdata;
  logic [5:0]  dbg_maddr = '0;
  logic [7:0]  dbg_mbyte;
  logic        halted;
  logic        misalign;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] prog [32];

  always #5 clk = ~clk;

  rcore_top i_rcore_top (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .dbg_reg(dbg_reg), .dbg_rdata(dbg_rdata), .dbg_maddr(dbg_maddr),
    .dbg_mbyte(dbg_mbyte), .halted(halted), .misalign(misalign)
  );

  function automatic logic [31:0] enc_r(input int fn, input int rs, input int rt, input int rd);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_reg(input string req, input int idx, input logic [31:0] exp);
    dbg_reg = 5'(idx);
    #1;
    chk(req, $sformatf("reg %0d", idx), dbg_rdata, exp);
  endtask

  task automatic chk_word_bytes(input string req, input int base, input logic [31:0] w);
    for (int k = 0; k < 4; k++) begin
      dbg_maddr = 6'(base + k);
      #1;
      chk(req, $sformatf("byte %0d", base + k), {24'd0, dbg_mbyte}, {24'd0, 8'(w >> (8 * (3 - k)))});
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 32; i++) prog[i] = 32'd0;
  endtask

  task automatic load_and_run(input int cycles);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 32; i++) begin
      ld_en = 1'b1; ld_addr = 5'(i); ld_data = prog[i];
      @(negedge clk);
    end
    ld_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    repeat (cycles) @(posedge clk);
    @(negedge clk);
  endtask

  // Array update A[8] = A[2] - b with a byte-order check
  task automatic t_array_update();
    logic [31:0] v, b, d;
    clear_prog();
    prog[0] = enc_i(8, 0, 19, 8);
    prog[1] = enc_i(8, 0, 8, 16'h1234);
    for (int i = 2; i < 18; i++) prog[i] = enc_r(32, 8, 8, 8);
    prog[18] = enc_i(8, 8, 8, 16'h5678);
    prog[19] = enc_i(43, 19, 8, 8);
    prog[20] = enc_i(8, 0, 18, 16'h0078);
    prog[21] = enc_i(35, 19, 9, 8);
    prog[22] = enc_r(34, 9, 18, 9);
    prog[23] = enc_i(43, 19, 9, 32);
    prog[24] = enc_r(32, 8, 8, 0);
    load_and_run(40);
    v = (32'h1234 << 16) + 32'h5678;
    b = 32'h78;
    d = v - b;
    chk_reg("R4", 19, 32'd8);
    chk_reg("R2", 8, v);
    chk_reg("R3", 9, d);
    chk_reg("R5", 18, b);
    chk_reg("R7", 0, 32'd0);
    chk_word_bytes("R6", 16, v);
    chk_word_bytes("R6", 40, d);
    chk("R8", "halted at empty word", {31'd0, halted}, 32'd1);
    chk("R9", "misalign", {31'd0, misalign}, 32'd0);
  endtask

  // Reset clears everything that the previous program set
  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk_reg("R1", 8, 32'd0);
    chk_reg("R1", 19, 32'd0);
    chk_word_bytes("R1", 16, 32'd0);
    chk("R1", "halted", {31'd0, halted}, 32'd0);
    chk("R1", "misalign", {31'd0, misalign}, 32'd0);
  endtask

  // Negative constants and offsets, wrap-around
  task automatic t_negative();
    logic [31:0] m4, twenty;
    m4 = 32'd0 - 32'd4;
    twenty = 32'd20;
    clear_prog();
    prog[0] = enc_i(8, 0, 1, -4);
    prog[1] = enc_i(8, 0, 2, 20);
    prog[2] = enc_i(43, 2, 1, -8);
    prog[3] = enc_i(35, 2, 3, -8);
    prog[4] = enc_i(35, 2, 4, -20);
    prog[5] = enc_r(34, 0, 2, 5);
    prog[6] = enc_r(32, 1, 1, 6);
    prog[7] = enc_r(34, 2, 1, 7);
    load_and_run(20);
    chk_reg("R4", 1, m4);
    chk_word_bytes("R6", 12, m4);
    chk_reg("R5", 3, m4);
    chk_reg("R5", 4, 32'd0);
    chk_reg("R3", 5, 32'd0 - twenty);
    chk_reg("R2", 6, m4 + m4);
    chk_reg("R3", 7, twenty - m4);
  endtask

  // Unsupported opcode and unsupported function code
  task automatic t_bad_encoding();
    clear_prog();
    prog[0] = enc_i(8, 0, 1, 5);
    prog[1] = {6'd63, 26'd0};
    prog[2] = enc_i(8, 0, 1, 9);
    load_and_run(20);
    chk_reg("R8", 1, 32'd5);
    chk("R8", "halted on bad op", {31'd0, halted}, 32'd1);
    chk("R8", "no misalign on bad op", {31'd0, misalign}, 32'd0);
    clear_prog();
    prog[0] = enc_i(8, 0, 2, 3);
    prog[1] = enc_r(36, 2, 2, 2);
    prog[2] = enc_i(8, 0, 3, 1);
    load_and_run(20);
    chk_reg("R8", 2, 32'd3);
    chk_reg("R8", 3, 32'd0);
    chk("R8", "halted on bad fn", {31'd0, halted}, 32'd1);
  endtask

  // Unaligned store and load
  task automatic t_misaligned();
    clear_prog();
    prog[0] = enc_i(8, 0, 1, 16'h55);
    prog[1] = enc_i(8, 0, 2, 2);
    prog[2] = enc_i(43, 2, 1, 1);
    prog[3] = enc_i(8, 0, 3, 7);
    load_and_run(20);
    chk_word_bytes("R9", 0, 32'd0);
    chk_word_bytes("R9", 4, 32'd0);
    chk_reg("R9", 3, 32'd0);
    chk("R9", "misalign after store", {31'd0, misalign}, 32'd1);
    chk("R9", "halted after store", {31'd0, halted}, 32'd1);
    clear_prog();
    prog[0] = enc_i(8, 0, 2, 6);
    prog[1] = enc_i(35, 2, 4, 0);
    prog[2] = enc_i(8, 0, 5, 1);
    load_and_run(20);
    chk_reg("R9", 4, 32'd0);
    chk_reg("R9", 5, 32'd0);
    chk("R9", "misalign after load", {31'd0, misalign}, 32'd1);
  endtask

  // Debug ports follow their address with no clock edge
  task automatic t_debug_comb();
    clear_prog();
    prog[0] = enc_i(8, 0, 10, 11);
    prog[1] = enc_i(8, 0, 11, 22);
    load_and_run(10);
    dbg_reg = 5'd10;
    #1;
    chk("R10", "reg 10 no clock", dbg_rdata, 32'd11);
    dbg_reg = 5'd11;
    #1;
    chk("R10", "reg 11 no clock", dbg_rdata, 32'd22);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    repeat (2) @(negedge clk);
    chk("R1", "halted in reset", {31'd0, halted}, 32'd0);
    chk_reg("R1", 5, 32'd0);
    t_array_update();
    t_reset();
    t_negative();
    t_bad_encoding();
    t_misaligned();
    t_debug_comb();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule